// File: doc/BRIEF.md
# Six-Phase Thyristor Firing Sequencer

This block produces six gate firing pulses for a three-phase controlled bridge. Its only timing input is a digital zero-crossing signal from a line comparator. A free-running timer is captured at each rising zero-crossing edge. The difference between two consecutive captures gives the line period, and integer division of that period by 360 gives the length of one electrical degree in clock cycles. At each zero-crossing reference, the sequencer waits a programmed number of degrees. It then fires the six gate lines one after another, 60 degrees apart.

The block is used beside a line comparator and a gate amplifier. The delay angle, in whole degrees, sets the bridge output voltage. The measured period and a validity flag are brought out so that a supervisor can see the line. A period outside the plausible window drops the validity flag and stops firing until the line is back in range. Each firing sequence is timed by the period measured over the interval between the two preceding references.

Top module: `sixfire_seq`

## Requirements
- R1: After reset all six firing lines are low, `period_valid` is 0 and `period_out` is 0, and no pulse fires before the third zero-crossing reference.
- R2: `zc_in` is synchronised by two flip-flops and edge detected. If `zc_in` is first sampled high at clock edge k, the reference event occurs at edge k+2. An input held high for many cycles yields a single reference.
- R3: At each reference after the first, `period_out` takes the timer value at this reference minus the timer value at the previous one, from the reference edge onward.
- R4: `period_valid` is 1 exactly when the last measured period lies within [PER_MIN, PER_MAX]. A reference whose preceding measurement was out of that window starts no sequence.
- R5: The degree length D equals floor(period / 360); the remainder is discarded.
- R6: For a reference sampled first at edge k with clamped delay angle A, `fire_out[0]` rises at edge k+3+A·D.
- R7: `fire_out[1]` to `fire_out[5]` rise in index order, each 60·D cycles after the previous line.
- R8: Each firing pulse stays high for exactly PULSE_W cycles, and at most one firing line is high at any time.
- R9: A `delay_deg` value above 359 acts as 359. The angle is sampled at the reference that starts a sequence.
- R10: A sequence uses D from the measurement that completed at the previous reference, and it latches D at its start. References that arrive while a sequence runs start nothing. After the sixth pulse the block waits for the next reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| zc_in | input | 1 | Asynchronous zero-crossing level from the line comparator |
| delay_deg | input | DEG_W | Firing delay angle in degrees |
| fire_out | output | 6 | Gate firing lines, bit 0 fires first |
| period_valid | output | 1 | Last measured period is inside the plausible window |
| period_out | output | TMR_W | Last measured line period in clock cycles |

## Verification
Counting from the clock edge that first samples `zc_in` high, the reference event, the period capture and the validity update all fall two edges later. Firing line i rises 3 + (A + 60·i)·D edges after that sampling edge and falls PULSE_W edges after it rose. The bench drives `zc_in` on falling edges and keeps a cycle count. From the spacing it chose, it derives the reference times, which sequences are accepted and every pulse window. It then compares all six lines at every falling edge against that schedule, and reads the period and flag at the end of each scenario, once the last capture has settled.

// File: rtl/sixfire_pkg.sv
package sixfire_pkg;
  localparam int unsigned DEG_PER_TURN = 360;
  localparam int unsigned PHASE_STEP   = 60;
  localparam int unsigned NUM_GATES    = 6;
  localparam int unsigned MAX_DELAY    = 359;
  localparam int unsigned LAST_ANGLE   = MAX_DELAY + (NUM_GATES - 1) * PHASE_STEP;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sixfire_zc_edge.sv
module sixfire_zc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_in,
  output logic zc_evt
);
  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], zc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // stage 1 is the second synchroniser flop, stage 2 its delayed copy
  assign zc_evt = sh_q[1] & ~sh_q[2];

  // R2: a held level yields one reference event only
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    zc_evt |=> !zc_evt);
endmodule

// File: rtl/sixfire_period_meter.sv
module sixfire_period_meter #(
  parameter int TMR_W   = 24,
  parameter int PER_MIN = 250000,
  parameter int PER_MAX = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_evt,
  output logic [TMR_W-1:0] period_o,
  output logic             valid_o,
  output logic             div_start_o,
  output logic             div_clear_o
);
  localparam logic [TMR_W-1:0] WIN_LO = TMR_W'(PER_MIN);
  localparam logic [TMR_W-1:0] WIN_HI = TMR_W'(PER_MAX);

  logic [TMR_W-1:0] tmr_q, tmr_d, cap_q, cap_d, per_q, per_d, delta;
  logic have_q, have_d, val_q, val_d, start_q, start_d, clr_q, clr_d, in_win;

  always_comb begin
    delta   = tmr_q - cap_q;
    in_win  = (delta >= WIN_LO) && (delta <= WIN_HI);
    tmr_d   = tmr_q + TMR_W'(1);
    cap_d   = cap_q;
    have_d  = have_q;
    per_d   = per_q;
    val_d   = val_q;
    start_d = 1'b0;
    clr_d   = 1'b0;
    if (zc_evt) begin
      cap_d  = tmr_q;
      have_d = 1'b1;
      if (have_q) begin
        per_d   = delta;
        val_d   = in_win;
        start_d = in_win;
        clr_d   = !in_win;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      cap_q   <= '0;
      per_q   <= '0;
      have_q  <= 1'b0;
      val_q   <= 1'b0;
      start_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      tmr_q   <= tmr_d;
      cap_q   <= cap_d;
      per_q   <= per_d;
      have_q  <= have_d;
      val_q   <= val_d;
      start_q <= start_d;
      clr_q   <= clr_d;
    end
  end

  assign period_o    = per_q;
  assign valid_o     = val_q;
  assign div_start_o = start_q;
  assign div_clear_o = clr_q;

  // R3: the period register only moves right after a reference
  a_r3_period_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_q) |-> $past(zc_evt));

  // R4: the flag never vouches for an out-of-window period
  a_r4_valid_window: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |-> (per_q >= WIN_LO && per_q <= WIN_HI));
endmodule

// File: rtl/sixfire_deg_div.sv
module sixfire_deg_div #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         clear_i,
  input  logic [W-1:0] dividend_i,
  output logic [W-1:0] deg_len_o,
  output logic         ok_o
);
  import sixfire_pkg::*;

  localparam logic [W-1:0] TURN = W'(DEG_PER_TURN);

  logic         busy_q, busy_d, ok_q, ok_d;
  logic [W-1:0] rem_q, rem_d, quo_q, quo_d, len_q, len_d, dvd_q, dvd_d;

  always_comb begin
    busy_d = busy_q;
    ok_d   = ok_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    len_d  = len_q;
    dvd_d  = dvd_q;
    if (start_i) begin
      rem_d  = dividend_i;
      dvd_d  = dividend_i;
      quo_d  = '0;
      busy_d = 1'b1;
      ok_d   = 1'b0;
    end else if (clear_i) begin
      busy_d = 1'b0;
      ok_d   = 1'b0;
    end else if (busy_q) begin
      if (rem_q >= TURN) begin
        rem_d = rem_q - TURN;
        quo_d = quo_q + W'(1);
      end else begin
        len_d  = quo_q;
        ok_d   = 1'b1;
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ok_q   <= 1'b0;
      rem_q  <= '0;
      quo_q  <= '0;
      len_q  <= '0;
      dvd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ok_q   <= ok_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      len_q  <= len_d;
      dvd_q  <= dvd_d;
    end
  end

  assign deg_len_o = len_q;
  assign ok_o      = ok_q;

  logic [W+9:0] chk_prod, chk_dvd;
  assign chk_prod = (W+10)'(len_q) * (W+10)'(DEG_PER_TURN);
  assign chk_dvd  = (W+10)'(dvd_q);

  // R5: a published degree length is the floor of period / 360
  a_r5_floor_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> (chk_prod <= chk_dvd) && (chk_dvd - chk_prod < (W+10)'(DEG_PER_TURN)));
endmodule

// File: rtl/sixfire_sequencer.sv
module sixfire_sequencer #(
  parameter int W       = 24,
  parameter int DEG_W   = 9,
  parameter int PULSE_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_evt,
  input  logic             arm_i,
  input  logic [W-1:0]     deg_len_i,
  input  logic [DEG_W-1:0] delay_i,
  output logic [5:0]       fire_o
);
  import sixfire_pkg::*;

  localparam int ANG_W = $clog2(LAST_ANGLE + 2);
  localparam int PW_W  = $clog2(PULSE_W + 1);

  seq_state_e       st_q, st_d;
  logic [W-1:0]     cyc_q, cyc_d, len_q, len_d;
  logic [ANG_W-1:0] ang_q, ang_d, tgt_q, tgt_d, dly_c;
  logic [2:0]       idx_q, idx_d;
  logic [5:0]       fire_q, fire_d;
  logic [PW_W-1:0]  wcnt_q, wcnt_d;
  logic [31:0]      dly_w;
  logic             fire_now, tick_end;

  always_comb begin
    dly_w    = 32'(delay_i);
    dly_c    = (dly_w > MAX_DELAY) ? ANG_W'(MAX_DELAY) : ANG_W'(dly_w);
    tick_end = (cyc_q == len_q - W'(1));
    fire_now = (st_q == SQ_RUN) && (cyc_q == '0) && (ang_q == tgt_q);

    st_d  = st_q;
    cyc_d = cyc_q;
    len_d = len_q;
    ang_d = ang_q;
    tgt_d = tgt_q;
    idx_d = idx_q;
    case (st_q)
      SQ_IDLE: begin
        if (zc_evt && arm_i) begin
          st_d  = SQ_RUN;
          cyc_d = '0;
          ang_d = '0;
          idx_d = '0;
          tgt_d = dly_c;
          len_d = deg_len_i;
        end
      end
      default: begin
        if (tick_end) begin
          cyc_d = '0;
          ang_d = ang_q + ANG_W'(1);
        end else begin
          cyc_d = cyc_q + W'(1);
        end
        if (fire_now) begin
          idx_d = idx_q + 3'd1;
          tgt_d = tgt_q + ANG_W'(PHASE_STEP);
          if (idx_q == 3'(NUM_GATES - 1)) st_d = SQ_IDLE;
        end
      end
    endcase

    fire_d = fire_q;
    wcnt_d = wcnt_q;
    if (fire_now) begin
      fire_d = 6'(1) << idx_q;
      wcnt_d = PW_W'(PULSE_W - 1);
    end else if (|fire_q) begin
      if (wcnt_q == '0) fire_d = '0;
      else              wcnt_d = wcnt_q - PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cyc_q  <= '0;
      len_q  <= '0;
      ang_q  <= '0;
      tgt_q  <= '0;
      idx_q  <= '0;
      fire_q <= '0;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      cyc_q  <= cyc_d;
      len_q  <= len_d;
      ang_q  <= ang_d;
      tgt_q  <= tgt_d;
      idx_q  <= idx_d;
      fire_q <= fire_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign fire_o = fire_q;

  // R8: never two gate lines at once
  a_r8_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_q));

  // R6: a pulse only starts on a degree boundary of a running sequence
  a_r6_rise_on_degree: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|fire_q) |-> $past(st_q == SQ_RUN && cyc_q == '0));

  // R9: the clamped angle keeps every target inside the last legal angle
  a_r9_target_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN) |-> (tgt_q <= ANG_W'(LAST_ANGLE)));

  // R10: the latched degree length holds for the whole sequence
  a_r10_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN && $past(st_q == SQ_RUN)) |-> $stable(len_q));
endmodule

// File: rtl/sixfire_seq.sv
module sixfire_seq #(
  parameter int TMR_W   = 24,
  parameter int DEG_W   = 9,
  parameter int PULSE_W = 20,
  parameter int PER_MIN = 250000,
  parameter int PER_MAX = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_in,
  input  logic [DEG_W-1:0] delay_deg,
  output logic [5:0]       fire_out,
  output logic             period_valid,
  output logic [TMR_W-1:0] period_out
);
  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             zc_evt, val, dstart, dclr, dok;
  logic [TMR_W-1:0] per, dlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  sixfire_zc_edge u_zc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .zc_in  (zc_in),
    .zc_evt (zc_evt)
  );

  sixfire_period_meter #(
    .TMR_W   (TMR_W),
    .PER_MIN (PER_MIN),
    .PER_MAX (PER_MAX)
  ) u_meter (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .zc_evt      (zc_evt),
    .period_o    (per),
    .valid_o     (val),
    .div_start_o (dstart),
    .div_clear_o (dclr)
  );

  sixfire_deg_div #(.W(TMR_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (dstart),
    .clear_i    (dclr),
    .dividend_i (per),
    .deg_len_o  (dlen),
    .ok_o       (dok)
  );

  sixfire_sequencer #(
    .W       (TMR_W),
    .DEG_W   (DEG_W),
    .PULSE_W (PULSE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .zc_evt    (zc_evt),
    .arm_i     (val & dok),
    .deg_len_i (dlen),
    .delay_i   (delay_deg),
    .fire_o    (fire_out)
  );

  assign period_valid = val;
  assign period_out   = per;

  // R4: firing requires a valid measurement
  a_r4_fire_needs_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(|fire_out) && $past(zc_evt, 2) |-> $past(val, 2));
endmodule

// File: tb/sixfire_seq_bench.sv
module sixfire_seq_bench;
  localparam int TW  = 16;
  localparam int PW  = 3;
  localparam int PMN = 600;
  localparam int PMX = 1200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          zc_in = 1'b0;
  logic [8:0]    delay_deg = '0;
  logic [5:0]    fire_out;
  logic          period_valid;
  logic [TW-1:0] period_out;

  sixfire_seq #(
    .TMR_W(TW), .DEG_W(9), .PULSE_W(PW), .PER_MIN(PMN), .PER_MAX(PMX)
  ) u_sixfire_seq (
    .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .delay_deg(delay_deg),
    .fire_out(fire_out), .period_valid(period_valid), .period_out(period_out)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  int gaps[16];
  int ref_c[16];
  int s_ref[16];
  int s_d[16];
  int ns;
  int s_dc;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    zc_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "fire_out after reset", int'(fire_out), 0);
    check("R1", "period_valid after reset", int'(period_valid), 0);
    check("R1", "period_out after reset", int'(period_out), 0);
  endtask

  task automatic set_gaps(int g);
    for (int i = 0; i < 16; i++) gaps[i] = g;
  endtask

  function automatic logic [5:0] exp_fire(int t);
    logic [5:0] v = '0;
    for (int s = 0; s < ns; s++)
      for (int i = 0; i < 6; i++) begin
        int r = s_ref[s] + 4 + (s_dc + 60 * i) * s_d[s];
        if (t >= r && t < r + PW) v[i] = 1'b1;
      end
    return v;
  endfunction

  task automatic run_scn(string tag, int dly, int n_refs, int hold);
    int t_end;
    int last_end;
    delay_deg = 9'(dly);
    do_reset();
    @(negedge clk);
    ref_c[0] = cyc + 2;
    for (int j = 1; j < n_refs; j++) ref_c[j] = ref_c[j-1] + gaps[j-1];
    s_dc = (dly > 359) ? 359 : dly;
    ns = 0;
    last_end = -1;
    for (int j = 2; j < n_refs; j++) begin
      int g = ref_c[j-1] - ref_c[j-2];
      if (g >= PMN && g <= PMX && ref_c[j] > last_end) begin
        s_ref[ns] = ref_c[j];
        s_d[ns]   = g / 360;
        last_end  = ref_c[j] + (s_dc + 300) * s_d[ns] + 1;
        ns++;
      end
    end
    t_end = ref_c[n_refs-1] + 10;
    for (int s = 0; s < ns; s++) begin
      int e = s_ref[s] + 4 + (s_dc + 300) * s_d[s] + PW + 5;
      if (e > t_end) t_end = e;
    end
    while (cyc < t_end) begin
      logic zv;
      logic [5:0] ef;
      @(negedge clk);
      zv = 1'b0;
      for (int j = 0; j < n_refs; j++)
        if (cyc >= ref_c[j] && cyc < ref_c[j] + hold) zv = 1'b1;
      zc_in = zv;
      ef = exp_fire(cyc);
      n_chk++;
      if (fire_out !== ef) begin
        n_err++;
        $display("FAIL %s fire_out actual %b expected %b at cycle %0d", tag, fire_out, ef, cyc);
      end
    end
    if (n_refs >= 2) begin
      int g = gaps[n_refs-2];
      check("R3", "period_out", int'(period_out), g);
      check("R4", "period_valid", int'(period_valid), (g >= PMN && g <= PMX) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R10 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R6: zero delay, first sequence at third reference
    set_gaps(720);
    run_scn("R6", 0, 3, 3);
    // R7: consecutive sequences, 60-degree stagger, D = 2
    set_gaps(720);
    run_scn("R7", 1, 6, 3);
    // R9: angle above 359 clamps, long sequences skip references
    set_gaps(720);
    run_scn("R9", 400, 5, 3);
    // R10: references during a running sequence are ignored
    set_gaps(720);
    run_scn("R10", 250, 6, 3);
    // R5: remainder discarded, 1081 / 360 = 3
    set_gaps(1081);
    run_scn("R5", 30, 4, 3);
    // R10: window edge 1200, reference lands one edge before idle
    set_gaps(1200);
    run_scn("R10", 100, 4, 3);
    // R4: short and long intervals suppress the following reference
    set_gaps(720);
    gaps[1] = 599;
    gaps[4] = 1201;
    run_scn("R4", 20, 7, 3);
    // R4: out-of-window last measurement clears the flag
    set_gaps(720);
    gaps[1] = 1300;
    run_scn("R4", 5, 3, 3);
    // R8: D = 1 at lower window edge, pulse width and exclusivity
    set_gaps(600);
    run_scn("R8", 59, 4, 3);
    // R2: long high level on zc_in gives one reference each
    set_gaps(720);
    run_scn("R2", 10, 3, 300);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule